// File: doc/BRIEF.md
# Timer Pin Function Controller

This block controls the single IO pin of a general purpose timer. It takes its settings from a 32-bit mode word that is held elsewhere, and it keeps a small status word of its own. Depending on the function field, the pin can serve as a plain GPIO input, as a GPIO output, or as an edge source. A GPIO output can be push-pull or open-drain. An edge source latches an event flag and can raise a maskable interrupt. The pin level passes through a synchronizer before anything uses it.

The pad connects through a tri-state pair made of a drive value and an output enable. Software reads the status word, which carries the synchronized pin level and the event flag. It clears the flag by writing ones. Counting, prescaling and watchdog behaviour belong to neighbouring logic and are not part of this block.

Top module: `tmr_pin_ctrl`

## Requirements
- R1: After reset, `st_rdata` is zero, `irq_o` is low and `pin_oe` is low.
- R2: With function field `cfg_mode[2:0]`=4 (GPIO) and no edge selected, a drive field `cfg_mode[5:4]`=2'b10 drives the pin low (`pin_oe`=1, `pin_o`=0) and 2'b11 drives it high (`pin_oe`=1, `pin_o`=1).
- R3: The pin is never driven when the drive field is 2'b00 or 2'b01, or when the function field is anything other than 4. The other function codes are 0 off, 1 capture, 2 compare and 3 PWM.
- R4: When open-drain select `cfg_mode[9]` is set, a GPIO output of high releases the pin (`pin_oe`=0) and a low output drives 0. In open-drain mode `pin_o` is never 1 while `pin_oe` is 1.
- R5: `st_rdata[8]` shows the pin level after a two-flop synchronizer. A change at `pin_i` appears there after the second rising clock edge.
- R6: The edge field `cfg_mode[17:16]` selects which pin transitions set the event flag `st_rdata[0]`. The encodings are 01 rising, 10 falling, 11 both and 00 none. The flag is set on the third rising clock edge after the pin changes, which is the cycle after the synchronized edge is seen.
- R7: Edges set the flag only when the function field is 1 (capture) or 4 (GPIO). With function 0, 2 or 3, edges leave the flag clear.
- R8: Writing with `st_clr_en` high and `st_clr_bits[0]`=1 clears the flag on the next edge. Writing a 0 in that bit leaves the flag unchanged. Status bits 7:1 and 31:9 read as zero.
- R9: If a clear write happens in the same cycle as a new selected edge, the flag stays set.
- R10: `irq_o` is high exactly when the flag is set and interrupt enable `cfg_mode[8]` is 1.
- R11: When a nonzero edge field is programmed in function 1 or 4, the pin acts only as an input. Output drive is suppressed (`pin_oe`=0) whatever the drive field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 32 | Mode word from the timer's register |
| st_clr_en | input | 1 | Status write strobe |
| st_clr_bits | input | 4 | Write-one-to-clear data for status bits 3:0 |
| st_rdata | output | 32 | Status word: bit 8 pin level, bit 0 event flag |
| pin_i | input | 1 | Pad input level (asynchronous) |
| pin_o | output | 1 | Pad drive value |
| pin_oe | output | 1 | Pad output enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties take `pin_i` to be a level that the synchronizer samples, with no meaning attached to changes shorter than a clock cycle. They also take the mode word to be settled while a capture is in progress, because a change to the function or edge field between the synchronized edge and the flag update would break the one-cycle edge-to-flag relation. The stimulus only rewrites `cfg_mode` while the pin has been steady for several cycles. It changes the pin on falling clock edges and holds it for longer than the synchronizer depth. Before each capture scenario it clears any flag left over from a mode change.

// File: rtl/tmr_pin_ctrl.sv
module tmr_pin_ctrl #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_mode,
  input  logic        st_clr_en,
  input  logic [3:0]  st_clr_bits,
  output logic [31:0] st_rdata,
  input  logic        pin_i,
  output logic        pin_o,
  output logic        pin_oe,
  output logic        irq_o
);
  localparam logic [2:0] FN_CAPTURE = 3'd1;
  localparam logic [2:0] FN_GPIO    = 3'd4;
  localparam int         LVL_BIT    = SYNC_DEPTH - 1;

  logic [SYNC_DEPTH-1:0] sync_q;
  logic                  lvl_prev;
  logic                  evt_flag;

  wire [2:0] fn       = cfg_mode[2:0];
  wire [1:0] drv_fld  = cfg_mode[5:4];
  wire       open_drn = cfg_mode[9];
  wire       irq_en   = cfg_mode[8];
  wire [1:0] edge_sel = cfg_mode[17:16];

  wire lvl     = sync_q[LVL_BIT];
  wire rise    = lvl & ~lvl_prev;
  wire fall    = ~lvl & lvl_prev;
  wire cap_on  = ((fn == FN_CAPTURE) || (fn == FN_GPIO)) && (edge_sel != 2'b00);
  wire evt     = cap_on & ((edge_sel[0] & rise) | (edge_sel[1] & fall));
  wire clr_hit = st_clr_en & st_clr_bits[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= '0;
      lvl_prev <= 1'b0;
      evt_flag <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_DEPTH-2:0], pin_i};
      lvl_prev <= lvl;
      evt_flag <= evt | (evt_flag & ~clr_hit);
    end
  end

  wire drv_on  = (fn == FN_GPIO) && drv_fld[1] && !cap_on;
  wire drv_val = drv_fld[0];

  assign pin_oe   = drv_on & (open_drn ? ~drv_val : 1'b1);
  assign pin_o    = drv_on & drv_val & ~open_drn;
  assign irq_o    = evt_flag & irq_en;
  assign st_rdata = {23'd0, lvl, 7'd0, evt_flag};
endmodule

// File: rtl/tmr_pin_ctrl_chk.sv
module tmr_pin_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cfg_mode,
  input logic        st_clr_en,
  input logic [3:0]  st_clr_bits,
  input logic [31:0] st_rdata,
  input logic        pin_o,
  input logic        pin_oe,
  input logic        irq_o
);
  AST_OE_ONLY_GPIO: assert property (@(posedge clk) disable iff (!rst_n) pin_oe |-> (cfg_mode[2:0] == 3'd4)); // R3
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (pin_oe && cfg_mode[9]) |-> !pin_o); // R4
  AST_FLAG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n) $rose(st_rdata[0]) |-> ($past(st_rdata[8]) != $past(st_rdata[8], 2))); // R6
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (st_rdata[0] && !(st_clr_en && st_clr_bits[0])) |=> st_rdata[0]); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> (cfg_mode[8] && st_rdata[0])); // R10
  AST_CAPTURE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) ((cfg_mode[17:16] != 2'b00) && ((cfg_mode[2:0] == 3'd1) || (cfg_mode[2:0] == 3'd4))) |-> !pin_oe); // R11
endmodule

bind tmr_pin_ctrl tmr_pin_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .st_clr_en(st_clr_en),
  .st_clr_bits(st_clr_bits), .st_rdata(st_rdata), .pin_o(pin_o),
  .pin_oe(pin_oe), .irq_o(irq_o)
);

// File: tb/tmr_pin_ctrl_test.sv
module tmr_pin_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_mode = '0;
  logic        st_clr_en = 1'b0;
  logic [3:0]  st_clr_bits = '0;
  logic [31:0] st_rdata;
  logic        pin_i = 1'b0;
  logic        pin_o, pin_oe, irq_o;
  int          n_chk = 0;
  int          n_err = 0;

  always #2 clk = ~clk;

  tmr_pin_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .st_clr_en(st_clr_en),
    .st_clr_bits(st_clr_bits), .st_rdata(st_rdata), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe(pin_oe), .irq_o(irq_o)
  );

  function automatic logic [31:0] mk(input logic [2:0] fn, input logic [1:0] esel,
                                     input logic [1:0] drv, input logic od, input logic ie);
    logic [31:0] m;
    m = '0;
    m[2:0] = fn; m[5:4] = drv; m[8] = ie; m[9] = od; m[17:16] = esel;
    return m;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_flag();
    st_clr_en = 1'b1; st_clr_bits = 4'hF;
    step(1);
    st_clr_en = 1'b0; st_clr_bits = 4'h0;
  endtask

  task automatic edge_case(input string tag, input logic [2:0] fn, input logic [1:0] esel,
                           input logic from_v, input logic to_v, input logic exp_f);
    cfg_mode = '0; pin_i = from_v;
    step(4);
    cfg_mode = mk(fn, esel, 2'b00, 1'b0, 1'b0);
    step(1);
    clear_flag();
    pin_i = to_v;
    step(2);
    chk({tag, " flag not early"}, {31'd0, st_rdata[0]}, 32'd0);
    step(1);
    chk({tag, " flag"}, {31'd0, st_rdata[0]}, {31'd0, exp_f});
  endtask

  task automatic t_reset();
    chk("R1 status", st_rdata, 32'd0);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    chk("R1 oe", {31'd0, pin_oe}, 32'd0);
  endtask

  task automatic t_gpio_out();
    cfg_mode = mk(3'd4, 2'b00, 2'b10, 1'b0, 1'b0); step(1);
    chk("R2 low oe", {31'd0, pin_oe}, 32'd1);
    chk("R2 low val", {31'd0, pin_o}, 32'd0);
    cfg_mode = mk(3'd4, 2'b00, 2'b11, 1'b0, 1'b0); step(1);
    chk("R2 high oe", {31'd0, pin_oe}, 32'd1);
    chk("R2 high val", {31'd0, pin_o}, 32'd1);
    cfg_mode = mk(3'd4, 2'b00, 2'b00, 1'b0, 1'b0); step(1);
    chk("R3 input 00", {31'd0, pin_oe}, 32'd0);
    cfg_mode = mk(3'd4, 2'b00, 2'b01, 1'b0, 1'b0); step(1);
    chk("R3 input 01", {31'd0, pin_oe}, 32'd0);
    for (int f = 0; f < 8; f++) begin
      if (f != 4) begin
        cfg_mode = mk(3'(f), 2'b00, 2'b11, 1'b0, 1'b0); step(1);
        chk($sformatf("R3 fn %0d no drive", f), {31'd0, pin_oe}, 32'd0);
      end
    end
  endtask

  task automatic t_open_drain();
    cfg_mode = mk(3'd4, 2'b00, 2'b11, 1'b1, 1'b0); step(1);
    chk("R4 od high released", {31'd0, pin_oe}, 32'd0);
    cfg_mode = mk(3'd4, 2'b00, 2'b10, 1'b1, 1'b0); step(1);
    chk("R4 od low oe", {31'd0, pin_oe}, 32'd1);
    chk("R4 od low val", {31'd0, pin_o}, 32'd0);
  endtask

  task automatic t_level();
    cfg_mode = '0; pin_i = 1'b0; step(4);
    pin_i = 1'b1;
    step(1);
    chk("R5 level after 1 edge", {31'd0, st_rdata[8]}, 32'd0);
    step(1);
    chk("R5 level after 2 edges", {31'd0, st_rdata[8]}, 32'd1);
    pin_i = 1'b0; step(2);
    chk("R5 level low", {31'd0, st_rdata[8]}, 32'd0);
  endtask

  task automatic t_edges();
    edge_case("R6 rise/rise", 3'd1, 2'b01, 1'b0, 1'b1, 1'b1);
    edge_case("R6 rise/fall", 3'd1, 2'b01, 1'b1, 1'b0, 1'b0);
    edge_case("R6 fall/fall", 3'd1, 2'b10, 1'b1, 1'b0, 1'b1);
    edge_case("R6 fall/rise", 3'd1, 2'b10, 1'b0, 1'b1, 1'b0);
    edge_case("R6 both/rise", 3'd1, 2'b11, 1'b0, 1'b1, 1'b1);
    edge_case("R6 both/fall", 3'd1, 2'b11, 1'b1, 1'b0, 1'b1);
    edge_case("R6 none", 3'd1, 2'b00, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_modes();
    edge_case("R7 gpio fn", 3'd4, 2'b11, 1'b0, 1'b1, 1'b1);
    edge_case("R7 off fn", 3'd0, 2'b11, 1'b0, 1'b1, 1'b0);
    edge_case("R7 compare fn", 3'd2, 2'b11, 1'b1, 1'b0, 1'b0);
    edge_case("R7 pwm fn", 3'd3, 2'b11, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_clear();
    edge_case("R8 setup", 3'd1, 2'b01, 1'b0, 1'b1, 1'b1);
    st_clr_en = 1'b1; st_clr_bits = 4'b1110; step(1);
    st_clr_en = 1'b0; st_clr_bits = 4'h0;
    chk("R8 zero write keeps", {31'd0, st_rdata[0]}, 32'd1);
    chk("R8 reserved bits", st_rdata & 32'hFFFF_FEFE, 32'd0);
    st_clr_en = 1'b1; st_clr_bits = 4'b0001; step(1);
    st_clr_en = 1'b0; st_clr_bits = 4'h0;
    chk("R8 one write clears", {31'd0, st_rdata[0]}, 32'd0);
  endtask

  task automatic t_collide();
    edge_case("R9 setup", 3'd1, 2'b11, 1'b0, 1'b1, 1'b1);
    pin_i = 1'b0;
    step(2);
    st_clr_en = 1'b1; st_clr_bits = 4'b0001;
    step(1);
    st_clr_en = 1'b0; st_clr_bits = 4'h0;
    chk("R9 edge wins over clear", {31'd0, st_rdata[0]}, 32'd1);
    clear_flag();
    chk("R9 later clear", {31'd0, st_rdata[0]}, 32'd0);
  endtask

  task automatic t_irq();
    edge_case("R10 setup", 3'd1, 2'b01, 1'b0, 1'b1, 1'b1);
    chk("R10 masked", {31'd0, irq_o}, 32'd0);
    cfg_mode = mk(3'd1, 2'b01, 2'b00, 1'b0, 1'b1); step(1);
    chk("R10 enabled", {31'd0, irq_o}, 32'd1);
    clear_flag();
    chk("R10 cleared", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_suppress();
    cfg_mode = mk(3'd4, 2'b01, 2'b11, 1'b0, 1'b0); step(1);
    chk("R11 gpio+edge no drive", {31'd0, pin_oe}, 32'd0);
    cfg_mode = mk(3'd4, 2'b10, 2'b10, 1'b1, 1'b0); step(1);
    chk("R11 od+edge no drive", {31'd0, pin_oe}, 32'd0);
    cfg_mode = mk(3'd4, 2'b00, 2'b11, 1'b0, 1'b0); step(1);
    chk("R11 drive returns", {31'd0, pin_oe}, 32'd1);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_gpio_out();
    t_open_drain();
    t_level();
    t_edges();
    t_modes();
    t_clear();
    t_collide();
    t_irq();
    t_suppress();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule